// File: doc/BRIEF.md
# Single-Slope Pulse-Height Conversion Sequencer

This block holds the digital half of a run-down pulse-height converter. A discriminator trigger starts each conversion. The block first closes an external sample switch for a short acceptance window, so that the pulse can charge the external peak-hold stage. It then opens the switch and keeps it open for a long dead time. During that dead time the held voltage is discharged at a constant rate by external circuitry, and an external comparator stays high until the voltage reaches ground.

The block counts clock cycles while the synchronised comparator is high. It does this in an 8-bit counter built from cascaded 4-bit stages. When counting stops, it presents the count as a channel number together with a one-cycle strobe. The channel number is proportional to the pulse height and is ready for an external histogram. After the dead time the block is armed again for the next trigger.

Top module: `pha_sequencer`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge), `sw_close`, `ch_valid`, `ch_ovf` are 0 and `channel` is 0.
- R2: A rising edge of `trig_in` while idle reaches the sequencer through a two-flop synchroniser and an edge detector. It then drives `sw_close` high for exactly `ACC_CYC` consecutive clock cycles.
- R3: When the acceptance window ends, `sw_close` is low for a dead time of `DEAD_CYC` cycles. Trigger edges during the acceptance window or the dead time start nothing: `sw_close` stays low.
- R4: During the dead time only, the count advances by one on each clock cycle while the comparator, after its two-flop synchroniser, is high. The low 4-bit stage carries into the high 4-bit stage. Cycles in the acceptance window are never counted.
- R5: On the first dead-time cycle with the synchronised comparator low, the count is latched to `channel` and `ch_valid` is high for exactly one cycle. This happens at most once per conversion. A comparator that is already low gives channel 0.
- R6: The count saturates at 255. `ch_ovf` is 1 with the result only if more than 255 cycles were counted. Exactly 255 counted cycles gives channel 255 with `ch_ovf` 0.
- R7: If the comparator is still high when the dead time expires, the result is latched and strobed at expiry. `ch_valid` then rises `DEAD_CYC` cycles after `sw_close` falls.
- R8: Once the dead time has expired the block waits for a new rising trigger edge. A trigger held high across the whole sequence does not start a second one.
- R9: The counter and overflow state clear at the start of each conversion. `channel` and `ch_ovf` hold the last result until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_in | input | 1 | Asynchronous pulse trigger from discriminator |
| cmp_in | input | 1 | Asynchronous run-down comparator output, high while held voltage above ground |
| sw_close | output | 1 | Sample switch enable, high = switch closed (acceptance window) |
| channel | output | 8 | Latched channel number |
| ch_valid | output | 1 | One-cycle strobe, channel valid |
| ch_ovf | output | 1 | Result saturated (more than 255 counted cycles) |

## Verification
The bench builds the block with `ACC_CYC` = 16 and `DEAD_CYC` = 320, which keeps each conversion to a few hundred cycles. Because the dead time exceeds 256 cycles, the bench can reach exactly 255 counts, one count past saturation, and the dead-time expiry case with the comparator held high. Comparator release is placed at exact cycle offsets into the dead time. Each expected channel is therefore two synchroniser cycles plus that offset, which also exercises the nibble carry.

// File: rtl/pha_seq_pkg.sv
package pha_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCEPT = 2'd1,
        ST_DEAD   = 2'd2
    } seq_state_t;
endpackage

// File: rtl/pha_sync2.sv
module pha_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.s1 = d;
        r_d.s2 = r_q.s1;
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign q = r_q.s2;
endmodule

// File: rtl/pha_cascade_counter.sv
module pha_cascade_counter #(
    parameter int STAGE_W  = 4,
    parameter int N_STAGES = 2,
    localparam int TOT_W   = STAGE_W * N_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [TOT_W-1:0] count,
    output logic [TOT_W-1:0] count_nxt,
    output logic             full
);
    logic [STAGE_W-1:0] stg_q [N_STAGES];
    logic [STAGE_W-1:0] stg_d [N_STAGES];
    logic [N_STAGES-1:0] stg_full;
    logic [N_STAGES-1:0] carry;

    assign full = &stg_full;

    for (genvar i = 0; i < N_STAGES; i++) begin : g_stage
        assign stg_full[i] = &stg_q[i];
        if (i == 0) begin : g_first
            assign carry[i] = inc & ~full;
        end else begin : g_next
            assign carry[i] = carry[i-1] & stg_full[i-1];
        end

        always_comb begin
            stg_d[i] = stg_q[i];
            if (clr)           stg_d[i] = '0;
            else if (carry[i]) stg_d[i] = stg_q[i] + 1'b1;
        end

        always_ff @(posedge clk) begin
            if (rst) stg_q[i] <= '0;
            else     stg_q[i] <= stg_d[i];
        end

        assign count[i*STAGE_W +: STAGE_W]     = stg_q[i];
        assign count_nxt[i*STAGE_W +: STAGE_W] = stg_d[i];
    end

    // R4: without a clear the count never moves backwards
    assert_count_monotonic_R4: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (count >= $past(count)));
    // R6: a saturated counter holds its value
    assert_sat_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (full && !clr) |=> full);
endmodule

// File: rtl/pha_sequencer.sv
module pha_sequencer
    import pha_seq_pkg::*;
#(
    parameter int ACC_CYC  = 5000,
    parameter int DEAD_CYC = 100000,
    parameter int STAGE_W  = 4,
    parameter int N_STAGES = 2,
    localparam int CH_W    = STAGE_W * N_STAGES,
    localparam int TMR_MAX = (ACC_CYC > DEAD_CYC) ? ACC_CYC : DEAD_CYC,
    localparam int TMR_W   = $clog2(TMR_MAX + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            trig_in,
    input  logic            cmp_in,
    output logic            sw_close,
    output logic [CH_W-1:0] channel,
    output logic            ch_valid,
    output logic            ch_ovf
);
    localparam logic [TMR_W-1:0] ACC_LAST  = TMR_W'(ACC_CYC - 1);
    localparam logic [TMR_W-1:0] DEAD_LAST = TMR_W'(DEAD_CYC - 1);

    typedef struct packed {
        seq_state_t      state;
        logic [TMR_W-1:0] tmr;
        logic            trig_prev;
        logic            done;
        logic            ovf;
        logic [CH_W-1:0] channel;
        logic            valid;
        logic            ch_ovf;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic [1:0] sync_s;
    logic       trig_s, cmp_s, trig_rise;
    logic       cnt_clr, cnt_inc, cnt_full;
    logic [CH_W-1:0] cnt_val, cnt_nxt;

    pha_sync2 #(.W(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({trig_in, cmp_in}),
        .q   (sync_s)
    );
    assign trig_s    = sync_s[1];
    assign cmp_s     = sync_s[0];
    assign trig_rise = trig_s & ~r_q.trig_prev;

    pha_cascade_counter #(.STAGE_W(STAGE_W), .N_STAGES(N_STAGES)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .clr       (cnt_clr),
        .inc       (cnt_inc),
        .count     (cnt_val),
        .count_nxt (cnt_nxt),
        .full      (cnt_full)
    );

    always_comb begin
        r_d           = r_q;
        r_d.valid     = 1'b0;
        r_d.trig_prev = trig_s;
        cnt_clr       = 1'b0;
        cnt_inc       = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (trig_rise) begin
                    r_d.state = ST_ACCEPT;
                    r_d.tmr   = '0;
                    r_d.done  = 1'b0;
                    r_d.ovf   = 1'b0;
                    cnt_clr   = 1'b1;
                end
            end
            ST_ACCEPT: begin
                if (r_q.tmr == ACC_LAST) begin
                    r_d.state = ST_DEAD;
                    r_d.tmr   = '0;
                end else begin
                    r_d.tmr = r_q.tmr + 1'b1;
                end
            end
            ST_DEAD: begin
                if (!r_q.done) begin
                    if (cmp_s) begin
                        cnt_inc = 1'b1;
                        if (cnt_full) r_d.ovf = 1'b1;
                    end
                    if (!cmp_s || r_q.tmr == DEAD_LAST) begin
                        r_d.channel = cnt_nxt;
                        r_d.ch_ovf  = r_d.ovf;
                        r_d.valid   = 1'b1;
                        r_d.done    = 1'b1;
                    end
                end
                if (r_q.tmr == DEAD_LAST) begin
                    r_d.state = ST_IDLE;
                    r_d.tmr   = '0;
                end else begin
                    r_d.tmr = r_q.tmr + 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign sw_close = (r_q.state == ST_ACCEPT);
    assign channel  = r_q.channel;
    assign ch_valid = r_q.valid;
    assign ch_ovf   = r_q.ch_ovf;

    // R5: strobe lasts a single cycle
    assert_valid_single_R5: assert property (@(posedge clk) disable iff (rst)
        ch_valid |=> !ch_valid);
    // R6: overflow only reported with a saturated channel
    assert_ovf_full_R6: assert property (@(posedge clk) disable iff (rst)
        (ch_valid && ch_ovf) |-> (channel == {CH_W{1'b1}}));
    // R3: the switch does not reclose right after the acceptance window
    assert_no_reclose_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(sw_close) |=> !sw_close);
    // R3: dead time never jumps straight back to acceptance
    assert_dead_blocks_R3: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_DEAD) |=> (r_q.state != ST_ACCEPT));
    // R4: no counting while the switch is closed
    assert_no_count_accept_R4: assert property (@(posedge clk) disable iff (rst)
        (sw_close && $past(sw_close)) |=> $stable(cnt_val));
endmodule

// File: tb/pha_sequencer_test.sv
module pha_sequencer_test;
    localparam int ACC  = 16;
    localparam int DEAD = 320;
    localparam int NV   = 6;
    localparam int VEC_K  [NV] = '{0, 5, 40, 253, 254, 300};
    localparam int VEC_CH [NV] = '{2, 7, 42, 255, 255, 255};
    localparam int VEC_OV [NV] = '{0, 0, 0, 0, 1, 1};

    logic clk = 1'b0;
    logic rst, trig_in, cmp_in;
    logic sw_close, ch_valid, ch_ovf;
    logic [7:0] channel;
    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    pha_sequencer #(.ACC_CYC(ACC), .DEAD_CYC(DEAD)) uut (
        .clk(clk), .rst(rst), .trig_in(trig_in), .cmp_in(cmp_in),
        .sw_close(sw_close), .channel(channel), .ch_valid(ch_valid), .ch_ovf(ch_ovf)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // start a conversion and return after sw_close has fallen (negedge n0)
    task automatic start_conv(input bit hold_trig, output int width);
        int tmo = 0;
        trig_in = 1'b1;
        while (!sw_close && tmo < 50) begin @(negedge clk); tmo++; end
        width = 0;
        while (sw_close && width < 100) begin
            @(negedge clk);
            width++;
            if (width == 4 && !hold_trig) trig_in = 1'b0;
        end
        if (!hold_trig) trig_in = 1'b0;
    endtask

    task automatic wait_valid(output int n);
        n = 0;
        while (!ch_valid && n < 600) begin @(negedge clk); n++; end
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int w, n;
        rst = 1'b1; trig_in = 1'b0; cmp_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(sw_close == 0, "R1 sw_close", sw_close, 0);
        chk(ch_valid == 0, "R1 ch_valid", ch_valid, 0);
        chk(channel == 0,  "R1 channel", channel, 0);
        chk(ch_ovf == 0,   "R1 ch_ovf", ch_ovf, 0);

        // vector table: comparator released k cycles into the dead time
        for (int v = 0; v < NV; v++) begin
            cmp_in = 1'b1;
            repeat (3) @(negedge clk);
            start_conv(1'b0, w);
            chk(w == ACC, "R2 acceptance width", w, ACC);
            repeat (VEC_K[v]) @(negedge clk);
            cmp_in = 1'b0;
            wait_valid(n);
            chk(ch_valid == 1, "R5 strobe seen", ch_valid, 1);
            chk(channel == VEC_CH[v], "R4 R6 channel", channel, VEC_CH[v]);
            chk(ch_ovf == VEC_OV[v], "R6 overflow", ch_ovf, VEC_OV[v]);
            @(negedge clk);
            chk(ch_valid == 0, "R5 strobe one cycle", ch_valid, 0);
            repeat (DEAD + 5) @(negedge clk);
            chk(channel == VEC_CH[v], "R9 channel held", channel, VEC_CH[v]);
        end

        // comparator already low: channel 0, overflow cleared from last run
        start_conv(1'b0, w);
        wait_valid(n);
        chk(n == 1, "R5 immediate strobe delay", n, 1);
        chk(channel == 0, "R5 R9 zero channel", channel, 0);
        chk(ch_ovf == 0, "R9 ovf cleared", ch_ovf, 0);
        repeat (DEAD + 5) @(negedge clk);

        // comparator high through dead time, trigger held high: expiry latch and no restart
        cmp_in = 1'b1;
        repeat (3) @(negedge clk);
        start_conv(1'b1, w);
        chk(w == ACC, "R2 width held trigger", w, ACC);
        wait_valid(n);
        chk(n == DEAD, "R7 expiry strobe delay", n, DEAD);
        chk(channel == 255, "R7 expiry channel", channel, 255);
        chk(ch_ovf == 1, "R7 expiry ovf", ch_ovf, 1);
        begin
            int seen = 0;
            for (int i = 0; i < 30; i++) begin @(negedge clk); if (sw_close) seen = 1; end
            chk(seen == 0, "R8 held trigger no restart", seen, 0);
        end
        trig_in = 1'b0;
        cmp_in = 1'b0;
        repeat (5) @(negedge clk);

        // trigger edges during acceptance and dead time are ignored
        cmp_in = 1'b1;
        repeat (3) @(negedge clk);
        trig_in = 1'b1;
        while (!sw_close) @(negedge clk);
        trig_in = 1'b0; repeat (3) @(negedge clk);
        trig_in = 1'b1; repeat (3) @(negedge clk);
        trig_in = 1'b0;
        while (sw_close) @(negedge clk);
        repeat (10) @(negedge clk);
        cmp_in = 1'b0;
        wait_valid(n);
        chk(channel == 12, "R4 channel after retrigger", channel, 12);
        begin
            int seen = 0;
            trig_in = 1'b1; repeat (4) @(negedge clk); trig_in = 1'b0;
            for (int i = 0; i < DEAD; i++) begin @(negedge clk); if (sw_close) seen = 1; end
            chk(seen == 0, "R3 dead-time trigger ignored", seen, 0);
        end
        repeat (5) @(negedge clk);
        start_conv(1'b0, w);
        chk(w == ACC, "R8 rearmed after dead time", w, ACC);
        repeat (10) @(negedge clk);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule